// File: doc/BRIEF.md
# Flash Command-Word Sequencer

This block drives a serial flash bus from a queue of typed 32-bit command words. Software writes words into a command FIFO. A one-entry prefetch stage pulls the next word while the bus engine runs the current one. Each word shifts out an opcode byte, shifts out an address byte, clocks dummy cycles, or holds the bus quiet for idle cycles. Every word also carries the chip-select pattern that the bus shows while that word runs. A complete transfer is a script of such words. It starts with a pull-up idle with no select and a setup idle with the select low. The command, address and dummy words follow, and a hold idle ends it.

Only the low 18 bits of a word carry meaning, so the write port is 18 bits wide and the upper bits are not wired. The opcode and address phases each take their lane width from a configuration input. Words of any other type are consumed with no bus effect. The fill level counts only the words still waiting in the FIFO. A zero level therefore does not mean the bus is idle: one word may still be running and another may sit in the prefetch stage.

Top module: `flash_cmd_seq`

## Requirements
- R1: Each cycle with `cmd_wr` high appends `cmd_word` to a 16-deep FIFO. `fill_level` gives the number of words waiting in the FIFO and does not count the prefetched word or the executing word, so it can read 0 while a word is pending.
- R2: A write while `fill_level` equals the depth is dropped and has no effect on the bus. It sets `overflow`, which then stays high until reset.
- R3: Words run strictly in write order, one at a time. A prefetched word starts in the same clock cycle that the previous word finishes.
- R4: The word type is bits [17:14]: 0x5 opcode byte, 0x6 address byte, 0xB dummy, 0xC idle. A word of any other type is consumed with no clock edge and no change on `cs_n`.
- R5: Bits [13:10] drive `cs_n[3:0]` directly, active low: 0xE selects device 0, 0xD selects device 1, 0xF selects none. The value is applied when a word of a known type starts and is held until the next such word starts.
- R6: Opcode and address words send bits [7:0] most significant bit first. A lane code w (0=1, 1=2, 2=4, 3=8 lanes) comes from `cfg_cmd_lanes` for opcode words and from `cfg_addr_lanes` for address words, sampled when the word starts. Each clock carries 2^w bits on `dq_out[2^w-1:0]`, with the earliest bit on the highest lane. `dq_oe` is then the low 2^w bits set, so a byte takes 8/2^w clocks.
- R7: A dummy word with count N (bits [9:0]) gives N+1 serial clocks with `dq_oe` at 0.
- R8: An idle word with count N holds `sck` low and `dq_oe` at 0 for N×4 core cycles while showing its select pattern. A count of 0 only updates the select.
- R9: Each serial clock lasts 4 core cycles, low for the first half and high for the second, with data changing only while it is low. `sck` stays low whenever no clocked word runs.
- R10: After reset, `cs_n` is 0xF, `sck` is 0, `dq_oe` is 0, `fill_level` is 0 and `overflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cmd_wr | input | 1 | write strobe for the command FIFO |
| cmd_word | input | 18 | command word: type, select pattern, argument |
| cfg_cmd_lanes | input | 2 | lane code for opcode words |
| cfg_addr_lanes | input | 2 | lane code for address words |
| fill_level | output | 5 | words waiting in the FIFO |
| overflow | output | 1 | sticky flag, set by a write to a full FIFO |
| cs_n | output | 4 | active-low chip selects |
| sck | output | 1 | serial clock |
| dq_out | output | 8 | serial data lanes |
| dq_oe | output | 8 | per-lane output enable |

## Verification
The scoreboard rebuilds each byte from the rising serial-clock edges under single-, dual-, quad- and octal-lane settings, and on both selects. This shows whether lane order, bit order and lane choice per phase are right. Framed transfers with dummy counts of 7 and 0 separate the N+1 rule from an off-by-one. A measured idle window checks that idle time scales with the count and stays free of clock edges.

A long idle that holds words in the prefetch stage and the FIFO shows that the fill level excludes pending work. The same run fills the FIFO past its depth with opcodes that must never reach the bus. A word of unknown type is placed between selected idles to show that it leaves both the select and the clock untouched.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int ARG_W  = 10;
    localparam int SEL_W  = 4;
    localparam int KIND_W = 4;
    localparam int WORD_W = KIND_W + SEL_W + ARG_W;

    localparam logic [KIND_W-1:0] KIND_OPC = 4'h5;
    localparam logic [KIND_W-1:0] KIND_ADR = 4'h6;
    localparam logic [KIND_W-1:0] KIND_DMY = 4'hB;
    localparam logic [KIND_W-1:0] KIND_IDL = 4'hC;

    // field layout follows the bit positions of the command word
    typedef struct packed {
        logic [KIND_W-1:0] kind;
        logic [SEL_W-1:0]  sel;
        logic [ARG_W-1:0]  arg;
    } cmd_t;

    function automatic logic [7:0] lane_mask(input logic [1:0] w);
        case (w)
            2'd0:    return 8'h01;
            2'd1:    return 8'h03;
            2'd2:    return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

    // most significant pending bit lands on the highest enabled lane
    function automatic logic [7:0] lane_drive(input logic [7:0] sr, input logic [1:0] w);
        case (w)
            2'd0:    return {7'd0, sr[7]};
            2'd1:    return {6'd0, sr[7:6]};
            2'd2:    return {4'd0, sr[7:4]};
            default: return sr;
        endcase
    endfunction

    function automatic logic [7:0] lane_shift(input logic [7:0] sr, input logic [1:0] w);
        case (w)
            2'd0:    return {sr[6:0], 1'b0};
            2'd1:    return {sr[5:0], 2'b0};
            2'd2:    return {sr[3:0], 4'b0};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [3:0] byte_beats(input logic [1:0] w);
        case (w)
            2'd0:    return 4'd8;
            2'd1:    return 4'd4;
            2'd2:    return 4'd2;
            default: return 4'd1;
        endcase
    endfunction

endpackage

// File: rtl/fcs_cmd_fifo.sv
module fcs_cmd_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 18
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [W-1:0]               wr_data,
    input  logic                       rd_en,
    output logic [W-1:0]               rd_data,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       overflow
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          ovf;
    } fifo_st_t;

    fifo_st_t     st_q, st_d;
    logic [W-1:0] mem [DEPTH];
    logic         accept;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d   = st_q;
        accept = wr_en && (st_q.cnt != CW'(DEPTH));
        if (accept)
            st_d.wp = ptr_inc(st_q.wp);
        if (rd_en)
            st_d.rp = ptr_inc(st_q.rp);
        case ({accept, rd_en})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
        if (wr_en && !accept)
            st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (accept)
            mem[st_q.wp] <= wr_data;
    end

    assign rd_data  = mem[st_q.rp];
    assign empty    = (st_q.cnt == '0);
    assign level    = st_q.cnt;
    assign overflow = st_q.ovf;

    a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));
    a_r2_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && level == CW'(DEPTH) && !rd_en) |=> (level == CW'(DEPTH)));
    a_r2_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

endmodule

// File: rtl/fcs_prefetch.sv
module fcs_prefetch
    import fcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fifo_empty,
    input  cmd_t  fifo_word,
    input  logic  take,
    output logic  pop,
    output logic  pf_valid,
    output cmd_t  pf_word
);
    typedef struct packed {
        logic valid;
        cmd_t word;
    } pf_st_t;

    pf_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        pop  = !fifo_empty && (!st_q.valid || take);
        if (pop) begin
            st_d.valid = 1'b1;
            st_d.word  = fifo_word;
        end else if (take) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign pf_valid = st_q.valid;
    assign pf_word  = st_q.word;

    a_r3_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !take) |=> (pf_valid && $stable(pf_word)));

endmodule

// File: rtl/fcs_bus_engine.sv
module fcs_bus_engine
    import fcs_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pf_valid,
    input  cmd_t             pf_word,
    input  logic [1:0]       cfg_cmd_lanes,
    input  logic [1:0]       cfg_addr_lanes,
    output logic             take,
    output logic [SEL_W-1:0] cs_n,
    output logic             sck,
    output logic [7:0]       dq_out,
    output logic [7:0]       dq_oe
);
    localparam int DW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam int BW   = ARG_W + 1;
    localparam int HALF = CLK_DIV / 2;
    localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);

    typedef struct packed {
        logic              active;
        logic [KIND_W-1:0] kind;
        logic [1:0]        lanes;
        logic [7:0]        sr;
        logic [BW-1:0]     beats;
        logic [DW-1:0]     div;
        logic [SEL_W-1:0]  cs_n;
    } eng_st_t;

    eng_st_t       st_q, st_d;
    logic          fin;
    logic          known;
    logic [BW-1:0] new_beats;
    logic [1:0]    new_lanes;
    logic          shifting;

    always_comb begin
        st_d      = st_q;
        take      = 1'b0;
        known     = 1'b1;
        new_beats = '0;
        new_lanes = st_q.lanes;
        fin       = st_q.active && (st_q.div == DIV_LAST) && (st_q.beats == BW'(1));

        if (st_q.active) begin
            if (st_q.div == DIV_LAST) begin
                st_d.div   = '0;
                st_d.beats = st_q.beats - BW'(1);
                st_d.sr    = lane_shift(st_q.sr, st_q.lanes);
                if (st_q.beats == BW'(1))
                    st_d.active = 1'b0;
            end else begin
                st_d.div = st_q.div + DW'(1);
            end
        end

        if (pf_valid && (!st_q.active || fin)) begin
            take = 1'b1;
            case (pf_word.kind)
                KIND_OPC: begin
                    new_lanes = cfg_cmd_lanes;
                    new_beats = BW'(byte_beats(cfg_cmd_lanes));
                end
                KIND_ADR: begin
                    new_lanes = cfg_addr_lanes;
                    new_beats = BW'(byte_beats(cfg_addr_lanes));
                end
                KIND_DMY: new_beats = {1'b0, pf_word.arg} + BW'(1);
                KIND_IDL: new_beats = {1'b0, pf_word.arg};
                default:  known = 1'b0;
            endcase
            if (known) begin
                st_d.kind   = pf_word.kind;
                st_d.cs_n   = pf_word.sel;
                st_d.sr     = pf_word.arg[7:0];
                st_d.lanes  = new_lanes;
                st_d.beats  = new_beats;
                st_d.div    = '0;
                st_d.active = (new_beats != '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cs_n <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign shifting = st_q.active && (st_q.kind == KIND_OPC || st_q.kind == KIND_ADR);
    assign sck      = st_q.active && (st_q.kind != KIND_IDL) && (st_q.div >= DW'(HALF));
    assign dq_oe    = shifting ? lane_mask(st_q.lanes) : 8'h00;
    assign dq_out   = shifting ? lane_drive(st_q.sr, st_q.lanes) : 8'h00;
    assign cs_n     = st_q.cs_n;

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.kind == KIND_IDL) |-> (!sck && dq_oe == 8'h00));
    a_r6_lane_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
        ((dq_oe + 8'd1) & dq_oe) == 8'h00);
    a_r9_no_clock_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.active |-> !sck);
    a_r5_select_held: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(cs_n));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CLK_DIV    = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cmd_wr,
    input  logic [17:0]                     cmd_word,
    input  logic [1:0]                      cfg_cmd_lanes,
    input  logic [1:0]                      cfg_addr_lanes,
    output logic [$clog2(FIFO_DEPTH+1)-1:0] fill_level,
    output logic                            overflow,
    output logic [3:0]                      cs_n,
    output logic                            sck,
    output logic [7:0]                      dq_out,
    output logic [7:0]                      dq_oe
);
    cmd_t fifo_word;
    cmd_t pf_word;
    logic fifo_empty;
    logic pop;
    logic pf_valid;
    logic take;

    fcs_cmd_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (WORD_W)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cmd_wr),
        .wr_data  (cmd_word),
        .rd_en    (pop),
        .rd_data  (fifo_word),
        .empty    (fifo_empty),
        .level    (fill_level),
        .overflow (overflow)
    );

    fcs_prefetch u_prefetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .fifo_word  (fifo_word),
        .take       (take),
        .pop        (pop),
        .pf_valid   (pf_valid),
        .pf_word    (pf_word)
    );

    fcs_bus_engine #(
        .CLK_DIV (CLK_DIV)
    ) u_engine (
        .clk            (clk),
        .rst_n          (rst_n),
        .pf_valid       (pf_valid),
        .pf_word        (pf_word),
        .cfg_cmd_lanes  (cfg_cmd_lanes),
        .cfg_addr_lanes (cfg_addr_lanes),
        .take           (take),
        .cs_n           (cs_n),
        .sck            (sck),
        .dq_out         (dq_out),
        .dq_oe          (dq_oe)
    );

    a_r1_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (fill_level != '0));

endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [17:0] cmd_word = '0;
    logic [1:0]  cfg_cmd_lanes = 2'd0;
    logic [1:0]  cfg_addr_lanes = 2'd0;
    logic [4:0]  fill_level;
    logic        overflow;
    logic [3:0]  cs_n;
    logic        sck;
    logic [7:0]  dq_out;
    logic [7:0]  dq_oe;

    always #5 clk = ~clk;

    flash_cmd_seq u_flash_cmd_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_wr         (cmd_wr),
        .cmd_word       (cmd_word),
        .cfg_cmd_lanes  (cfg_cmd_lanes),
        .cfg_addr_lanes (cfg_addr_lanes),
        .fill_level     (fill_level),
        .overflow       (overflow),
        .cs_n           (cs_n),
        .sck            (sck),
        .dq_out         (dq_out),
        .dq_oe          (dq_oe)
    );

    typedef struct packed {
        logic [3:0] cs;
        logic [7:0] oe;
        logic [7:0] b;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    int   last_rise = 0;
    int   rises = 0;
    int   dummy_edges = 0;
    int   sel0_cycles = 0;
    int   bits = 0;
    logic [7:0] acc = '0;
    logic sck_prev = 1'b0;

    function automatic logic [7:0] mask_of(input logic [1:0] w);
        return 8'((9'd1 << (4'd1 << w)) - 9'd1);
    endfunction

    function automatic logic [17:0] mk(input logic [3:0] k, input logic [3:0] s, input logic [9:0] a);
        return {k, s, a};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic put(input logic [17:0] w);
        @(negedge clk);
        cmd_wr   = 1'b1;
        cmd_word = w;
        @(posedge clk);
        #1 cmd_wr = 1'b0;
    endtask

    // driver: push the expected byte, then queue the word
    task automatic send_byte(input logic [3:0] k, input logic [3:0] s, input logic [7:0] b, input logic [1:0] w);
        exp_q.push_back('{cs: s, oe: mask_of(w), b: b});
        put(mk(k, s, {2'b00, b}));
    endtask

    task automatic idle_for(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: rebuild bytes on rising serial clock edges
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (cs_n == 4'hE) sel0_cycles++;
            if (sck && !sck_prev) begin
                rises++;
                if (dq_oe != 8'h00) begin
                    if (bits != 0) chk(cyc - last_rise == 4, "R9 clock period", cyc - last_rise, 4);
                    acc  = (acc << $countones(dq_oe)) | (dq_out & dq_oe);
                    bits = bits + $countones(dq_oe);
                    if (bits >= 8) begin
                        if (exp_q.size() == 0) begin
                            chk(1'b0, "R2 unexpected byte on bus", acc, 0);
                        end else begin
                            exp_t e;
                            e = exp_q.pop_front();
                            chk(acc === e.b, "R6 byte value", acc, e.b);
                            chk(dq_oe === e.oe, "R6 lane enable", dq_oe, e.oe);
                            chk(cs_n === e.cs, "R5 select during byte", cs_n, e.cs);
                        end
                        bits = 0;
                        acc  = '0;
                    end
                end else begin
                    dummy_edges++;
                end
                last_rise = cyc;
            end
            sck_prev = sck;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int r0;
        idle_for(3);
        chk(cs_n == 4'hF, "R10 select at reset", cs_n, 4'hF);
        chk(sck == 1'b0 && dq_oe == 8'h00, "R10 bus quiet at reset", {sck, dq_oe}, 0);
        chk(fill_level == 0 && overflow == 1'b0, "R10 fifo at reset", {overflow, fill_level}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle_for(2);

        // framed single-lane transfer on device 0 (R3 R6 R7 R9)
        dummy_edges = 0;
        put(mk(4'hC, 4'hF, 10'd2));
        put(mk(4'hC, 4'hE, 10'd1));
        send_byte(4'h5, 4'hE, 8'h9F, 2'd0);
        send_byte(4'h6, 4'hE, 8'h12, 2'd0);
        send_byte(4'h6, 4'hE, 8'h34, 2'd0);
        send_byte(4'h6, 4'hE, 8'h56, 2'd0);
        put(mk(4'hB, 4'hE, 10'd7));
        put(mk(4'hC, 4'hE, 10'd2));
        idle_for(300);
        chk(exp_q.size() == 0, "R3 all framed bytes sent", exp_q.size(), 0);
        chk(dummy_edges == 8, "R7 dummy count 7", dummy_edges, 8);
        chk(cs_n == 4'hE, "R5 select held after word", cs_n, 4'hE);
        put(mk(4'hC, 4'hF, 10'd0));
        idle_for(5);
        chk(cs_n == 4'hF, "R5 no select", cs_n, 4'hF);

        // octal opcode, quad address, device 1, dummy count 0 (R6 R7)
        cfg_cmd_lanes  = 2'd3;
        cfg_addr_lanes = 2'd2;
        dummy_edges = 0;
        put(mk(4'hC, 4'hD, 10'd1));
        send_byte(4'h5, 4'hD, 8'hEB, 2'd3);
        send_byte(4'h6, 4'hD, 8'hA5, 2'd2);
        send_byte(4'h6, 4'hD, 8'h3C, 2'd2);
        put(mk(4'hB, 4'hD, 10'd0));
        put(mk(4'hC, 4'hF, 10'd0));
        idle_for(120);
        chk(exp_q.size() == 0, "R6 wide lane bytes sent", exp_q.size(), 0);
        chk(dummy_edges == 1, "R7 dummy count 0", dummy_edges, 1);

        // dual lanes
        cfg_cmd_lanes  = 2'd1;
        cfg_addr_lanes = 2'd1;
        send_byte(4'h5, 4'hE, 8'hC6, 2'd1);
        send_byte(4'h6, 4'hE, 8'h81, 2'd1);
        put(mk(4'hC, 4'hF, 10'd0));
        idle_for(100);
        chk(exp_q.size() == 0, "R6 dual lane bytes sent", exp_q.size(), 0);
        cfg_cmd_lanes  = 2'd0;
        cfg_addr_lanes = 2'd0;

        // idle length (R8)
        sel0_cycles = 0;
        r0 = rises;
        put(mk(4'hC, 4'hF, 10'd0));
        put(mk(4'hC, 4'hE, 10'd5));
        put(mk(4'hC, 4'hF, 10'd0));
        idle_for(60);
        chk(sel0_cycles == 20, "R8 idle length", sel0_cycles, 20);
        chk(rises == r0, "R8 no clock during idle", rises - r0, 0);

        // prefetch, fill level and overflow (R1 R2 R3)
        put(mk(4'hC, 4'hF, 10'd1023));
        idle_for(6);
        send_byte(4'h5, 4'hE, 8'h55, 2'd0);
        idle_for(4);
        chk(fill_level == 0, "R1 level excludes prefetched word", fill_level, 0);
        chk(exp_q.size() == 1, "R3 pending word waits", exp_q.size(), 1);
        for (int i = 0; i < 3; i++) put(mk(4'hC, 4'hF, 10'd1));
        idle_for(2);
        chk(fill_level == 3, "R1 level after three writes", fill_level, 3);
        for (int i = 0; i < 13; i++) put(mk(4'hC, 4'hF, 10'd0));
        for (int i = 0; i < 3; i++) put(mk(4'h5, 4'hE, {2'b00, 8'hFF}));
        idle_for(2);
        chk(fill_level == 16, "R2 level at full", fill_level, 16);
        chk(overflow == 1'b1, "R2 overflow set", overflow, 1);
        idle_for(4400);
        chk(exp_q.size() == 0, "R3 prefetched byte sent in order", exp_q.size(), 0);
        chk(overflow == 1'b1, "R2 overflow sticky", overflow, 1);
        chk(fill_level == 0 && cs_n == 4'hF, "R2 dropped words absent", {cs_n, fill_level}, 8'hF0);

        // unknown type word (R4)
        r0 = rises;
        put(mk(4'hC, 4'hE, 10'd0));
        idle_for(10);
        put(mk(4'h8, 4'hF, 10'd3));
        idle_for(20);
        chk(cs_n == 4'hE, "R4 unknown word keeps select", cs_n, 4'hE);
        chk(rises == r0, "R4 unknown word no clock", rises - r0, 0);
        put(mk(4'hC, 4'hF, 10'd0));
        idle_for(10);
        chk(cs_n == 4'hF, "R5 select released", cs_n, 4'hF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule